// File: doc/BRIEF.md
# I2C Engine Status and Diagnostic Register Unit

This block is the host-facing register file of an I2C master engine. It decodes a small 32-bit register map in which several addresses mean one thing on a read and another on a write. Event pulses from the protocol engine are latched into sticky flags, which are shown in a status word and gated through an interrupt mask to form `irq_o`. Writes to some addresses do not store data. They either emit a one-cycle reset strobe or change the state of a bus line.

Setting a diagnostic bit in the mode register hands direct control of the SCL and SDA pull-downs to the host, for bus recovery by bit-banging. Clearing that bit gives the lines back to the protocol engine. The serial engine and the data FIFO live outside this unit. They connect through the event, busy, count and line pins.

Top module: `i2c_status_regs`

## Requirements
- R1: After reset the mode register and the interrupt mask read 0, no flag is set, both line pull-downs follow the engine inputs, and the status word (offset 0x1C) holds only its live and constant fields.
- R2: A one-cycle pulse on `ev_i[k]` sets status bit 23+k, and the bit stays set until it is cleared. Status bit 15 reads 1 whenever any of the bits 31:23 is set. The bit order from 31 down to 23 is: invalid command, parity, overrun, access, lost arbitration, NACK, data request, command complete, stop error.
- R3: A write to 0x20 clears every flag and raises `err_rst_o` for one cycle. It leaves the mode register unchanged. An event that arrives in the same cycle as this write stays set.
- R4: A write to 0x1C raises `eng_rst_o` for one cycle. It also clears the flags, the mode register, the interrupt mask, the port-busy bit and both line overrides.
- R5: The mode register at 0x08 stores only the bits under the mask 0xFFFF_FC0F. Bit 2 of the mode register is the diagnostic enable.
- R6: The interrupt mask at 0x10 holds bits 15:5, and other bits read 0. A write to 0x14 ORs the written data into the mask. A write to 0x18 ANDs the written data into the mask.
- R7: A read of 0x14 returns the condition vector: flags in bits 15:7, self busy in bit 6, idle (the inverse of self busy) in bit 5. A read of 0x18 returns the condition vector ANDed with the mask. `irq_o` is 1 whenever that AND is nonzero.
- R8: The status word shows the number of ports minus 1 in bits 22:16, live SCL in bit 11, live SDA in bit 10, port busy in bit 9, self busy in bit 8 and the FIFO count in bits 7:0.
- R9: The extended status word at 0x20 shows the FIFO depth in bits 31:24, live SCL and SDA in bits 15 and 14, the driven SCL and SDA pull-downs in bits 11 and 10, port busy in bit 7, self busy in bit 6 and the version in bits 4:0.
- R10: While diagnostic mode is on, a write to 0x2C pulls SCL low and a write to 0x24 releases it. A write to 0x34 pulls SDA low and a write to 0x30 releases it. While diagnostic mode is off, these writes are ignored.
- R11: While diagnostic mode is off, `scl_low_o` and `sda_low_o` follow the engine's requests. Leaving diagnostic mode also releases both overrides, so a later return to diagnostic mode starts with both lines released.
- R12: A pulse on `pbusy_set_i` sets port busy, which reads as bit 31 of 0x28. A write to 0x28 with data bit 31 set clears it. A write to 0x28 with data bit 31 clear has no effect.
- R13: A read of 0x24 returns the residual length input in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| rdata_o | output | 32 | Read data |
| ev_i | input | 9 | Engine event pulses; ev_i[k] maps to status bit 23+k |
| self_busy_i | input | 1 | Engine busy |
| pbusy_set_i | input | 1 | Sets the port-busy state |
| fifo_cnt_i | input | 8 | FIFO fill count |
| resid_i | input | 16 | Residual transfer length |
| scl_i | input | 1 | Live SCL level |
| sda_i | input | 1 | Live SDA level |
| eng_scl_low_i | input | 1 | Engine request to pull SCL low |
| eng_sda_low_i | input | 1 | Engine request to pull SDA low |
| mode_o | output | 32 | Current mode register |
| irq_o | output | 1 | Masked interrupt request |
| eng_rst_o | output | 1 | Engine reset strobe |
| err_rst_o | output | 1 | Error reset strobe |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |

## Verification
The hardest case to reach is an event pulse that lands in the very cycle the error-reset write is accepted. The bench reaches it with a write task that drives `ev_i` in the same cycle as the write to 0x20. A second hard case is a stale line override after diagnostic mode is left and entered again. To reach it, the bench pulls a line low, drops the diagnostic bit for at least one clock, sets the bit again, and checks that the line comes back released.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;
  localparam int NFLAG = 9;
  localparam int NLINE = 2;  // [1]=SCL, [0]=SDA
  localparam logic [31:0] MODE_WMASK = 32'hFFFF_FC0F;
  localparam int DIAG_BIT = 2;

  localparam logic [3:0] W_MODE  = 4'd2;
  localparam logic [3:0] W_MASK  = 4'd4;
  localparam logic [3:0] W_MOR   = 4'd5;
  localparam logic [3:0] W_MAND  = 4'd6;
  localparam logic [3:0] W_STAT  = 4'd7;
  localparam logic [3:0] W_ESTAT = 4'd8;
  localparam logic [3:0] W_RESID = 4'd9;
  localparam logic [3:0] W_PBUSY = 4'd10;
  localparam logic [3:0] W_SCLLO = 4'd11;
  localparam logic [3:0] W_SDAHI = 4'd12;
  localparam logic [3:0] W_SDALO = 4'd13;

  typedef struct packed {
    logic mode;
    logic mask;
    logic mor;
    logic mand;
    logic eng_rst;
    logic err_rst;
    logic scl_rel;
    logic pbusy;
    logic scl_low;
    logic sda_rel;
    logic sda_low;
  } wstb_t;
endpackage

// File: rtl/i2c_sr_dec.sv
module i2c_sr_dec
  import i2c_sr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wstb_t             wstb_o,
  output logic              rd_o,
  output logic [3:0]        rsel_o
);
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 4;

  logic hit;
  logic wr;

  generate
    if (ADDR_W > IDX_LSB + IDX_W) begin : g_hi
      assign hit = (addr_i[ADDR_W-1:IDX_LSB+IDX_W] == '0) && (addr_i[1:0] == 2'b00);
    end else begin : g_nohi
      assign hit = (addr_i[1:0] == 2'b00);
    end
  endgenerate

  assign rsel_o = addr_i[IDX_LSB+IDX_W-1:IDX_LSB];
  assign wr     = req_i & we_i & hit;
  assign rd_o   = req_i & ~we_i;

  always_comb begin
    wstb_o         = '0;
    wstb_o.mode    = wr && rsel_o == W_MODE;
    wstb_o.mask    = wr && rsel_o == W_MASK;
    wstb_o.mor     = wr && rsel_o == W_MOR;
    wstb_o.mand    = wr && rsel_o == W_MAND;
    wstb_o.eng_rst = wr && rsel_o == W_STAT;
    wstb_o.err_rst = wr && rsel_o == W_ESTAT;
    wstb_o.scl_rel = wr && rsel_o == W_RESID;
    wstb_o.pbusy   = wr && rsel_o == W_PBUSY;
    wstb_o.scl_low = wr && rsel_o == W_SCLLO;
    wstb_o.sda_rel = wr && rsel_o == W_SDAHI;
    wstb_o.sda_low = wr && rsel_o == W_SDALO;
  end
endmodule

// File: rtl/i2c_sr_flags.sv
module i2c_sr_flags
  import i2c_sr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] ev_i,
  input  logic             clr_i,
  input  logic             eng_rst_i,
  input  logic             pb_set_i,
  input  logic             pb_clr_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             pbusy_o
);
  logic [NFLAG-1:0] flags_q;
  logic             pbusy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      pbusy_q <= 1'b0;
    end else if (eng_rst_i) begin
      flags_q <= '0;
      pbusy_q <= 1'b0;
    end else begin
      // a new event beats a same-cycle clear
      flags_q <= (clr_i ? '0 : flags_q) | ev_i;
      if (pb_set_i)      pbusy_q <= 1'b1;
      else if (pb_clr_i) pbusy_q <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign pbusy_o = pbusy_q;

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !eng_rst_i |=> (flags_q & $past(flags_q)) == $past(flags_q));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && ev_i == '0 |=> flags_q == '0);

  assert_eng_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rst_i |=> flags_q == '0 && !pbusy_q);

  assert_pbusy_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_set_i && !eng_rst_i |=> pbusy_q);
endmodule

// File: rtl/i2c_sr_lines.sv
module i2c_sr_lines
  import i2c_sr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             diag_i,
  input  logic             eng_rst_i,
  input  logic [NLINE-1:0] low_wr_i,
  input  logic [NLINE-1:0] rel_wr_i,
  input  logic [NLINE-1:0] eng_low_i,
  output logic [NLINE-1:0] low_o
);
  logic [NLINE-1:0] ovr_q;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 ovr_q[g] <= 1'b0;
      else if (eng_rst_i || !diag_i) ovr_q[g] <= 1'b0;
      else if (low_wr_i[g])        ovr_q[g] <= 1'b1;
      else if (rel_wr_i[g])        ovr_q[g] <= 1'b0;
    end

    assign low_o[g] = diag_i ? ovr_q[g] : eng_low_i[g];

    assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !diag_i |=> !ovr_q[g]);

    assert_latch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      diag_i && !eng_rst_i && low_wr_i[g] |=> ovr_q[g]);
  end
endmodule

// File: rtl/i2c_status_regs.sv
module i2c_status_regs
  import i2c_sr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int NUM_PORTS  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int VERSION    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  input  logic [8:0]        ev_i,
  input  logic              self_busy_i,
  input  logic              pbusy_set_i,
  input  logic [7:0]        fifo_cnt_i,
  input  logic [15:0]       resid_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              eng_scl_low_i,
  input  logic              eng_sda_low_i,
  output logic [31:0]       mode_o,
  output logic              irq_o,
  output logic              eng_rst_o,
  output logic              err_rst_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  localparam logic [6:0] MAXP   = 7'(NUM_PORTS - 1);
  localparam logic [7:0] FDEPTH = 8'(FIFO_DEPTH);
  localparam logic [4:0] VER    = 5'(VERSION);

  wstb_t            wstb;
  logic             rd;
  logic [3:0]       rsel;
  logic [NFLAG-1:0] flags;
  logic             pbusy;
  logic [31:0]      mode_q;
  logic [10:0]      mask_q;   // bits 15:5
  logic [10:0]      cond;
  logic [31:0]      stat_w, estat_w, rmux;
  logic [1:0]       line_low;

  i2c_sr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i (req_i), .we_i (we_i), .addr_i (addr_i),
    .wstb_o(wstb), .rd_o (rd), .rsel_o (rsel)
  );

  i2c_sr_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_i),
    .clr_i    (wstb.err_rst),
    .eng_rst_i(wstb.eng_rst),
    .pb_set_i (pbusy_set_i),
    .pb_clr_i (wstb.pbusy & wdata_i[31]),
    .flags_o  (flags),
    .pbusy_o  (pbusy)
  );

  i2c_sr_lines u_lines (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .diag_i   (mode_q[DIAG_BIT]),
    .eng_rst_i(wstb.eng_rst),
    .low_wr_i ({wstb.scl_low, wstb.sda_low}),
    .rel_wr_i ({wstb.scl_rel, wstb.sda_rel}),
    .eng_low_i({eng_scl_low_i, eng_sda_low_i}),
    .low_o    (line_low)
  );

  assign scl_low_o = line_low[1];
  assign sda_low_o = line_low[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      mask_q    <= '0;
      eng_rst_o <= 1'b0;
      err_rst_o <= 1'b0;
    end else begin
      eng_rst_o <= wstb.eng_rst;
      err_rst_o <= wstb.err_rst;
      if (wstb.eng_rst) begin
        mode_q <= '0;
        mask_q <= '0;
      end else begin
        if (wstb.mode) mode_q <= wdata_i & MODE_WMASK;
        if (wstb.mask)      mask_q <= wdata_i[15:5];
        else if (wstb.mor)  mask_q <= mask_q | wdata_i[15:5];
        else if (wstb.mand) mask_q <= mask_q & wdata_i[15:5];
      end
    end
  end

  assign cond    = {flags, self_busy_i, ~self_busy_i};
  assign irq_o   = |(cond & mask_q);
  assign mode_o  = mode_q;

  assign stat_w  = {flags, MAXP, |flags, 3'b000, scl_i, sda_i, pbusy, self_busy_i, fifo_cnt_i};
  assign estat_w = {FDEPTH, 8'h00, scl_i, sda_i, 2'b00, scl_low_o, sda_low_o, 2'b00,
                    pbusy, self_busy_i, 1'b0, VER};

  always_comb begin
    case (rsel)
      W_MODE:  rmux = mode_q;
      W_MASK:  rmux = {16'h0, mask_q, 5'h0};
      W_MOR:   rmux = {16'h0, cond, 5'h0};
      W_MAND:  rmux = {16'h0, cond & mask_q, 5'h0};
      W_STAT:  rmux = stat_w;
      W_ESTAT: rmux = estat_w;
      W_RESID: rmux = {16'h0, resid_i};
      W_PBUSY: rmux = {pbusy, 31'h0};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rmux;
    end
  end

  assert_eng_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rst_o |-> mode_q == '0 && mask_q == '0);

  assert_err_keeps_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_rst_o |-> $stable(mode_q));

  assert_mode_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q & ~MODE_WMASK) == '0);
endmodule

// File: tb/sim_i2c_status_regs.sv
module sim_i2c_status_regs;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni, req, we;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata, mode;
  logic        rvalid, irq, eng_rst, err_rst, scl_low, sda_low;
  logic [8:0]  ev;
  logic        self_busy, pb_set, scl, sda, e_scl, e_sda;
  logic [7:0]  fifo;
  logic [15:0] resid;

  i2c_status_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .ev_i(ev),
    .self_busy_i(self_busy), .pbusy_set_i(pb_set), .fifo_cnt_i(fifo),
    .resid_i(resid), .scl_i(scl), .sda_i(sda), .eng_scl_low_i(e_scl),
    .eng_sda_low_i(e_sda), .mode_o(mode), .irq_o(irq), .eng_rst_o(eng_rst),
    .err_rst_o(err_rst), .scl_low_o(scl_low), .sda_low_o(sda_low)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  localparam logic [31:0] B = 32'h0003_0C00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ev(input logic [5:0] a, input logic [31:0] d, input logic [8:0] e);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; ev = e;
    @(negedge clk);
    req = 0; we = 0; ev = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_ev(a, d, '0);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic pulse_ev(input logic [8:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk("monitor unexpected rvalid", 32'h1, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; req = 0; we = 0; addr = '0; wdata = '0; ev = '0;
    self_busy = 0; pb_set = 0; fifo = '0; resid = '0; scl = 1; sda = 1;
    e_scl = 0; e_sda = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    rd(6'h1C, B, "R1 status after reset");
    rd(6'h08, 32'h0, "R1 mode after reset");
    rd(6'h10, 32'h0, "R1 mask after reset");
    chk("R1 scl_low after reset", {31'h0, scl_low}, 32'h0);

    // R2 sticky flags
    pulse_ev(9'h100);
    rd(6'h1C, B | 32'h8000_8000, "R2 invalid command flag");
    pulse_ev(9'h008);
    rd(6'h1C, B | 32'h8400_8000, "R2 nack flag added");
    repeat (3) @(negedge clk);
    rd(6'h1C, B | 32'h8400_8000, "R2 flags sticky");

    // R5 mode mask
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, 32'hFFFF_FC0F, "R5 mode writable bits");

    // R10 diag overrides
    wr(6'h2C, 0);
    chk("R10 scl pulled low", {31'h0, scl_low}, 32'h1);
    wr(6'h34, 0);
    chk("R10 sda pulled low", {31'h0, sda_low}, 32'h1);
    rd(6'h20, 32'h0800_CC01, "R9 extended status");
    wr(6'h24, 0);
    chk("R10 scl released", {31'h0, scl_low}, 32'h0);
    wr(6'h30, 0);
    chk("R10 sda released", {31'h0, sda_low}, 32'h0);

    // R3 error reset keeps mode
    wr(6'h20, 0);
    chk("R3 err_rst strobe", {31'h0, err_rst}, 32'h1);
    @(negedge clk);
    chk("R3 err_rst one cycle", {31'h0, err_rst}, 32'h0);
    rd(6'h1C, B, "R3 flags cleared");
    rd(6'h08, 32'hFFFF_FC0F, "R3 mode kept");

    // R11 leaving diag
    wr(6'h2C, 0);
    wr(6'h08, 32'h0000_0008);
    chk("R11 scl follows engine", {31'h0, scl_low}, 32'h0);
    e_sda = 1; #1;
    chk("R11 sda follows engine", {31'h0, sda_low}, 32'h1);
    e_sda = 0;
    wr(6'h08, 32'h0000_0004);
    chk("R11 override released on reentry", {31'h0, scl_low}, 32'h0);
    wr(6'h08, 32'h0);
    wr(6'h2C, 0);
    chk("R10 write ignored without diag", {31'h0, scl_low}, 32'h0);
    wr(6'h08, 32'h0000_0004);
    chk("R10 ignored write not latched", {31'h0, scl_low}, 32'h0);
    wr(6'h08, 32'h0);

    // R6 mask aliases
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0000_FFE0, "R6 mask width");
    wr(6'h10, 32'h0000_0100);
    wr(6'h14, 32'h0000_8000);
    rd(6'h10, 32'h0000_8100, "R6 or-write");
    wr(6'h18, 32'h0000_0100);
    rd(6'h10, 32'h0000_0100, "R6 and-write");

    // R7 condition and irq
    chk("R7 irq idle", {31'h0, irq}, 32'h0);
    pulse_ev(9'h002);
    chk("R7 irq on cmd complete", {31'h0, irq}, 32'h1);
    rd(6'h14, 32'h0000_0120, "R7 condition vector");
    rd(6'h18, 32'h0000_0100, "R7 masked pending");

    // R3 same-cycle event survives clear
    wr_ev(6'h20, 0, 9'h001);
    rd(6'h1C, B | 32'h0080_8000, "R3 event beats clear");

    // R8 live fields
    self_busy = 1; fifo = 8'h5A; scl = 0;
    rd(6'h1C, 32'h0083_855A, "R8 live status fields");
    self_busy = 0; fifo = 8'h00; scl = 1;

    // R12 port busy
    @(negedge clk); pb_set = 1;
    @(negedge clk); pb_set = 0;
    rd(6'h28, 32'h8000_0000, "R12 port busy set");
    rd(6'h1C, 32'h0083_8E00, "R12 port busy in status");
    wr(6'h28, 32'h0);
    rd(6'h28, 32'h8000_0000, "R12 write without bit31 ignored");
    wr(6'h28, 32'h8000_0000);
    rd(6'h28, 32'h0, "R12 port busy cleared");

    // R13 residual length
    resid = 16'h1234;
    rd(6'h24, 32'h0000_1234, "R13 residual read");

    // R4 engine reset
    wr(6'h08, 32'h0006_0404);
    wr(6'h2C, 0);
    @(negedge clk); pb_set = 1;
    @(negedge clk); pb_set = 0;
    wr(6'h1C, 0);
    chk("R4 eng_rst strobe", {31'h0, eng_rst}, 32'h1);
    chk("R4 scl override cleared", {31'h0, scl_low}, 32'h0);
    @(negedge clk);
    chk("R4 eng_rst one cycle", {31'h0, eng_rst}, 32'h0);
    rd(6'h08, 32'h0, "R4 mode cleared");
    rd(6'h10, 32'h0, "R4 mask cleared");
    rd(6'h1C, B, "R4 flags and port busy cleared");

    repeat (3) @(negedge clk);
    chk("monitor queue drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule